// File: doc/BRIEF.md
# Serial Command Frame Transmitter

This block turns one master command into a bit stream on a clocked, single-wire serial link. The data line is active low. The block produces the link clock and drives the data line. It also drives a direction signal that tells the pad when to drive the line and when to let it float as an input.

Three command kinds are supported:
- An addressed read or write of 1, 2 or 4 bytes.
- A short data-poll.
- A terminate.

The block builds the frame from the request fields, leads it with a start bit and sends it most significant bit first. It then appends a 4-bit check code and holds the line at idle level for a fixed echo period. After that it releases the line and reports completion. Receiving the slave's reply is left to a companion block, which takes over once the line is released.

Top module: `cmd_frame_tx`

## Requirements
- R1: After reset, and whenever no command is in flight, `dataOe` is 0, `busClk` is 1, `dataOut` is 1, `busy` is 0 and `done` is 0.
- R2: `start` is accepted only while `busy` is 0. A `start` pulse raised during a transfer changes neither the bit stream in flight nor what follows it: no second transfer begins after `done`.
- R3: Every bit cell lasts two `clk` cycles. In the first cycle `busClk` is 1 and the new data level is on `dataOut`. In the second cycle `busClk` is 0 and the data level is unchanged, so the data is set up before the falling edge and the cell ends with the rising edge.
- R4: The wire level is always the inverse of the logical bit. The first cell after acceptance is the start bit, a logical 1, sent as level 0.
- R5: With `cmdKind` = 2'b00, the frame sent after the start bit is, first to last:
  - `slaveId` (2 bits),
  - the opcode 3'b100,
  - a read flag (1 = read, taken from `isRead`),
  - a 21-bit address,
  - a ds bit,
  - then the write data bytes (writes only).
- R6: Size encoding from `sizeSel`:
  - 2'b00 means 1 byte: ds = 0 and the address is sent unchanged.
  - 2'b01 means 2 bytes: ds = 1 and address bit 0 is sent as 0.
  - 2'b10 or 2'b11 means 4 bytes: ds = 1 and address bits 1:0 are sent as 2'b01.
- R7: A write sends its bytes from `wrData[7:0]` upward, as many bytes as the size selects, each byte most significant bit first. A read sends no data bytes.
- R8: With `cmdKind` = 2'b01, the frame is `slaveId` followed by the opcode 3'b010.
- R9: With `cmdKind` = 2'b10 or 2'b11, the frame is `slaveId` followed by the opcode 6'b111111.
- R10: After the frame, 4 check bits are sent, most significant first. They are the remainder of polynomial x^4 + x + 1, with a zero initial value, taken over the start bit and all frame bits in transmit order.
- R11: After the check bits, 16 cells of logical 0 (line level 1) are sent as the echo delay.
- R12: In the cycle after the last echo cell, `done` is 1 for exactly one cycle while `busy` and `dataOe` are already 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, sampled while idle |
| cmdKind | input | 2 | 00 read/write, 01 data-poll, 1x terminate |
| slaveId | input | 2 | Target slave number |
| addr | input | 21 | Byte address for read/write |
| sizeSel | input | 2 | 00 one byte, 01 two bytes, 1x four bytes |
| isRead | input | 1 | 1 for a read, 0 for a write |
| wrData | input | 32 | Write bytes, byte 0 in bits 7:0 |
| busy | output | 1 | A command is in flight |
| done | output | 1 | One-cycle completion pulse |
| busClk | output | 1 | Link clock |
| dataOut | output | 1 | Link data level (active low) |
| dataOe | output | 1 | 1 while the master drives the data line |

## Verification
A `start` that is sampled at a clock edge shows up as the start-bit cell's high phase in the very next cycle. From then on, each logical bit takes exactly two cycles. The `done` pulse therefore lands 2 x (1 + frame length + 4 + 16) cycles after acceptance.

The bench works out the whole expected level sequence from the request fields before it drives `start`. It then compares every output at each falling clock edge, one entry per cycle. The two cycles that follow the sequence are also checked, for the completion pulse and the return to idle.

// File: rtl/txframe_pkg.sv
package txframe_pkg;
  localparam int ID_W      = 2;
  localparam int ADDR_W    = 21;
  localparam int CRC_W     = 4;
  localparam int MAX_BYTES = 4;
  localparam int HDR_BITS  = ID_W + 3 + 1 + ADDR_W + 1;
  localparam int FRAME_MAX = HDR_BITS + 8 * MAX_BYTES;
  localparam int LEN_W     = $clog2(FRAME_MAX + 1);

  typedef struct packed {
    logic load;
    logic stepStart;
    logic stepFrame;
    logic stepCrc;
  } strobe_t;

  // one serial step of the x^4 + x + 1 remainder
  function automatic logic [CRC_W-1:0] crcStep(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    crcStep = {c[CRC_W-2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
  endfunction
endpackage

// File: rtl/cmd_frame_dp.sv
module cmd_frame_dp
  import txframe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              stb,
  input  logic [1:0]           cmdKind,
  input  logic [ID_W-1:0]      slaveId,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           sizeSel,
  input  logic                 isRead,
  input  logic [8*MAX_BYTES-1:0] wrData,
  output logic [LEN_W-1:0]     frameLen,
  output logic                 frameBit,
  output logic                 crcBit
);
  logic [FRAME_MAX-1:0] shiftReg, frameNext;
  logic [LEN_W-1:0]     lenNext;
  logic [CRC_W-1:0]     crcReg;
  logic [ADDR_W-1:0]    addrAdj;
  logic                 dsBit;
  logic [2:0]           nBytes;

  always_comb begin
    addrAdj = addr;
    dsBit   = 1'b0;
    nBytes  = 3'd1;
    if (sizeSel == 2'b01) begin
      addrAdj[0] = 1'b0;
      dsBit      = 1'b1;
      nBytes     = 3'd2;
    end else if (sizeSel[1]) begin
      addrAdj[1:0] = 2'b01;
      dsBit        = 1'b1;
      nBytes       = 3'd4;
    end
  end

  always_comb begin
    frameNext = '0;
    lenNext   = '0;
    case (cmdKind)
      2'b00: begin
        frameNext[FRAME_MAX-1 -: HDR_BITS] = {slaveId, 3'b100, isRead, addrAdj, dsBit};
        lenNext = LEN_W'(HDR_BITS);
        if (!isRead) begin
          for (int i = 0; i < MAX_BYTES; i++) begin
            if (i < int'(nBytes))
              frameNext[FRAME_MAX-HDR_BITS-1-8*i -: 8] = wrData[8*i +: 8];
          end
          lenNext = LEN_W'(HDR_BITS) + LEN_W'({nBytes, 3'b000});
        end
      end
      2'b01: begin
        frameNext[FRAME_MAX-1 -: ID_W+3] = {slaveId, 3'b010};
        lenNext = LEN_W'(ID_W + 3);
      end
      default: begin
        frameNext[FRAME_MAX-1 -: ID_W+6] = {slaveId, 6'b111111};
        lenNext = LEN_W'(ID_W + 6);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      crcReg   <= '0;
      frameLen <= '0;
    end else if (stb.load) begin
      shiftReg <= frameNext;
      crcReg   <= '0;
      frameLen <= lenNext;
    end else if (stb.stepStart) begin
      crcReg <= crcStep(crcReg, 1'b1);
    end else if (stb.stepFrame) begin
      crcReg   <= crcStep(crcReg, shiftReg[FRAME_MAX-1]);
      shiftReg <= {shiftReg[FRAME_MAX-2:0], 1'b0};
    end else if (stb.stepCrc) begin
      crcReg <= {crcReg[CRC_W-2:0], 1'b0};
    end
  end

  assign frameBit = shiftReg[FRAME_MAX-1];
  assign crcBit   = crcReg[CRC_W-1];

  // R3: the control advances one thing at a time
  assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.load, stb.stepStart, stb.stepFrame, stb.stepCrc}));
  // R8: no frame is shorter than the data-poll frame
  assert_len_min_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> (frameLen >= LEN_W'(ID_W + 3)));
endmodule

// File: rtl/cmd_frame_ctrl.sv
module cmd_frame_ctrl
  import txframe_pkg::*;
#(
  parameter int ECHO_CELLS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] frameLen,
  input  logic             frameBit,
  input  logic             crcBit,
  output strobe_t          stb,
  output logic             busy,
  output logic             done,
  output logic             busClk,
  output logic             dataOut,
  output logic             dataOe
);
  localparam int CNT_MAX = (FRAME_MAX > ECHO_CELLS) ? FRAME_MAX : ECHO_CELLS;
  localparam int CW      = $clog2(CNT_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_FRAME, S_CRC, S_ECHO} state_e;
  state_e        state;
  logic          phLow;
  logic [CW-1:0] cnt;

  always_comb begin
    stb.load      = (state == S_IDLE) && start;
    stb.stepStart = (state == S_START) && phLow;
    stb.stepFrame = (state == S_FRAME) && phLow;
    stb.stepCrc   = (state == S_CRC) && phLow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phLow <= 1'b0;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (state == S_IDLE) begin
        phLow <= 1'b0;
        if (start) state <= S_START;
      end else if (!phLow) begin
        phLow <= 1'b1;
      end else begin
        phLow <= 1'b0;
        case (state)
          S_START: begin
            state <= S_FRAME;
            cnt   <= CW'(frameLen) - CW'(1);
          end
          S_FRAME: begin
            if (cnt == '0) begin
              state <= S_CRC;
              cnt   <= CW'(CRC_W - 1);
            end else cnt <= cnt - CW'(1);
          end
          S_CRC: begin
            if (cnt == '0) begin
              state <= S_ECHO;
              cnt   <= CW'(ECHO_CELLS - 1);
            end else cnt <= cnt - CW'(1);
          end
          default: begin
            if (cnt == '0) begin
              state <= S_IDLE;
              done  <= 1'b1;
            end else cnt <= cnt - CW'(1);
          end
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      S_START: dataOut = 1'b0;
      S_FRAME: dataOut = ~frameBit;
      S_CRC:   dataOut = ~crcBit;
      default: dataOut = 1'b1;
    endcase
  end

  assign busy   = (state != S_IDLE);
  assign dataOe = busy;
  assign busClk = ~phLow;

  // R2: a transfer only begins from an accepted request
  assert_accept_from_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));
  // R3: data holds across the falling clock edge
  assert_setup_before_fall_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busClk) |-> $stable(dataOut));
  // R12: completion is a single-cycle pulse
  assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R12: line already released when completion is reported
  assert_done_released_R12: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && !dataOe && busClk));
endmodule

// File: rtl/cmd_frame_tx.sv
module cmd_frame_tx
  import txframe_pkg::*;
#(
  parameter int ECHO_CELLS = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [1:0]  cmdKind,
  input  logic [1:0]  slaveId,
  input  logic [20:0] addr,
  input  logic [1:0]  sizeSel,
  input  logic        isRead,
  input  logic [31:0] wrData,
  output logic        busy,
  output logic        done,
  output logic        busClk,
  output logic        dataOut,
  output logic        dataOe
);
  strobe_t          stb;
  logic [LEN_W-1:0] frameLen;
  logic             frameBit, crcBit;

  cmd_frame_ctrl #(.ECHO_CELLS(ECHO_CELLS)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .frameLen(frameLen),
    .frameBit(frameBit), .crcBit(crcBit), .stb(stb), .busy(busy),
    .done(done), .busClk(busClk), .dataOut(dataOut), .dataOe(dataOe)
  );

  cmd_frame_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cmdKind(cmdKind), .slaveId(slaveId),
    .addr(addr), .sizeSel(sizeSel), .isRead(isRead), .wrData(wrData),
    .frameLen(frameLen), .frameBit(frameBit), .crcBit(crcBit)
  );
endmodule

// File: tb/cmd_frame_tx_bench.sv
module cmd_frame_tx_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  cmdKind = '0;
  logic [1:0]  slaveId = '0;
  logic [20:0] addr = '0;
  logic [1:0]  sizeSel = '0;
  logic        isRead = 1'b0;
  logic [31:0] wrData = '0;
  logic busy, done, busClk, dataOut, dataOe;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  bit    bitsQ[$];
  string tagQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_frame_tx u_cmd_frame_tx (
    .clk(clk), .rstN(rstN), .start(start), .cmdKind(cmdKind), .slaveId(slaveId),
    .addr(addr), .sizeSel(sizeSel), .isRead(isRead), .wrData(wrData),
    .busy(busy), .done(done), .busClk(busClk), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {busy,done,busClk,dataOut,dataOe} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic pushBits(input logic [31:0] v, input int w, input string tag);
    for (int i = w - 1; i >= 0; i--) begin
      bitsQ.push_back(v[i]);
      tagQ.push_back(tag);
    end
  endtask

  task automatic runCmd(input logic [1:0] kind, input logic [1:0] id, input logic [20:0] a,
                        input logic [1:0] sz, input logic rd, input logic [31:0] wd,
                        input string tag, input int pokeAt);
    logic [20:0] sa;
    logic        ds;
    int          nb;
    logic [3:0]  c;
    bitsQ = {};
    tagQ  = {};
    pushBits(1, 1, "R4");
    if (kind == 2'b00) begin
      sa = a; ds = 1'b0; nb = 1;
      if (sz == 2'b01) begin sa[0] = 1'b0; ds = 1'b1; nb = 2; end
      else if (sz[1]) begin sa[1:0] = 2'b01; ds = 1'b1; nb = 4; end
      pushBits(id, 2, tag);
      pushBits(3'b100, 3, tag);
      pushBits(rd, 1, tag);
      pushBits(sa, 21, "R6");
      pushBits(ds, 1, "R6");
      if (!rd) for (int b = 0; b < nb; b++) pushBits((wd >> (8*b)) & 32'hFF, 8, "R7");
    end else if (kind == 2'b01) begin
      pushBits(id, 2, tag);
      pushBits(3'b010, 3, tag);
    end else begin
      pushBits(id, 2, tag);
      pushBits(6'b111111, 6, tag);
    end
    c = '0;
    foreach (bitsQ[k]) begin
      logic fb;
      fb = bitsQ[k] ^ c[3];
      c = {c[2:0], 1'b0} ^ (fb ? 4'b0011 : 4'b0000);
    end
    pushBits(c, 4, "R10");
    for (int e = 0; e < 16; e++) pushBits(0, 1, "R11");

    @(negedge clk);
    cmdKind = kind; slaveId = id; addr = a; sizeSel = sz; isRead = rd; wrData = wd;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int s = 0; s < 2 * bitsQ.size(); s++) begin
      check({tagQ[s/2], "/R3"}, {busy, done, busClk, dataOut, dataOe},
            {1'b1, 1'b0, (s % 2 == 0), ~bitsQ[s/2], 1'b1});
      if (s == pokeAt) begin
        start = 1'b1; cmdKind = 2'b00; isRead = ~rd; addr = ~a; wrData = ~wd; slaveId = ~id;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check("R12", {busy, done, busClk, dataOut, dataOe}, 5'b01110);
    @(negedge clk);
    check("R2/R12", {busy, done, busClk, dataOut, dataOe}, 5'b00110);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {busy, done, busClk, dataOut, dataOe}, 5'b00110);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", {busy, done, busClk, dataOut, dataOe}, 5'b00110);
    runCmd(2'b00, 2'd2, 21'h1ABCDE, 2'b10, 1'b1, 32'h0, "R5", -1);
    runCmd(2'b00, 2'd1, 21'h0F0F3, 2'b00, 1'b0, 32'h000000A5, "R5", -1);
    runCmd(2'b00, 2'd3, 21'h12345, 2'b01, 1'b0, 32'h00001234, "R7", -1);
    runCmd(2'b00, 2'd0, 21'h1FFFFF, 2'b11, 1'b0, 32'hDEADBEEF, "R2", 20);
    runCmd(2'b00, 2'd1, 21'h00003, 2'b01, 1'b1, 32'hFFFFFFFF, "R5", 70);
    runCmd(2'b01, 2'd3, 21'h0, 2'b00, 1'b0, 32'h0, "R8", -1);
    runCmd(2'b10, 2'd0, 21'h0, 2'b00, 1'b0, 32'h0, "R9", -1);
    runCmd(2'b11, 2'd2, 21'h0, 2'b00, 1'b0, 32'h0, "R9", 3);
    @(negedge clk);
    check("R1", {busy, done, busClk, dataOut, dataOe}, 5'b00110);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule